// File: doc/BRIEF.md
# Lock Requester with Exponential Backoff

This block obtains a shared single-bit lock for one client by talking to memory over a simple request/response port. The client pulses `acq_i` to ask for the lock. The engine then reads the lock word with plain reads for as long as it reads busy. When a read returns free, it issues one atomic test-and-set. If that test-and-set returns the free value, the lock is owned and `grant_o` is raised.

A test-and-set that returns busy means another requester got there first. The engine then goes silent on the memory port for a backoff delay and afterwards resumes reading. Each such collision doubles the delay, up to a parameterised cap. The delay returns to its minimum when a new acquisition starts and after every successful one. While `grant_o` is high, a pulse on `rel_i` drops the grant and sends one write of the free value to the lock word.

Top module: `lock_backoff_req`

## Requirements
- R1: Under reset and afterwards until an acquire arrives, `grant_o` is low and `req_valid_o` is low.
- R2: Opcodes on `req_op_o` are read = 2'b00, write = 2'b01, test-and-set = 2'b10. The lock word encodes free as 0 and busy as 1. While reads return busy, the engine issues another read as soon as each response arrives and never issues a test-and-set.
- R3: A read response of 0 is followed in the next cycle by exactly one test-and-set request.
- R4: A test-and-set response of 0 raises `grant_o` in the cycle right after the response.
- R5: A test-and-set response of 1 keeps `grant_o` low and leaves `req_valid_o` low for exactly the current delay in cycles. After that, a read is requested.
- R6: Each collision doubles the delay. The first collision of an acquisition waits DLY_MIN cycles.
- R7: The delay never exceeds DLY_MAX; once doubling would pass it, the delay stays at DLY_MAX.
- R8: After a successful acquisition the delay is back at DLY_MIN, so the first collision of the next acquisition waits DLY_MIN cycles.
- R9: A `rel_i` pulse while granted drops `grant_o` in the next cycle and issues exactly one write with `req_wdata_o` = 0. No further request follows until the next acquire.
- R10: A request that is not accepted (`req_ready_i` low) holds `req_valid_o` and `req_op_o` unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_i | input | 1 | Client asks for the lock (sampled while idle) |
| rel_i | input | 1 | Client gives the lock back (sampled while granted) |
| grant_o | output | 1 | Lock is held for the client |
| req_valid_o | output | 1 | Memory request valid |
| req_ready_i | input | 1 | Memory accepts the request this cycle |
| req_op_o | output | 2 | Request opcode: read, write or test-and-set |
| req_wdata_o | output | 1 | Write data (free value) |
| rsp_valid_i | input | 1 | Memory response valid (read and test-and-set only) |
| rsp_old_i | input | 1 | Lock value before the access |

## Verification
A read or test-and-set accepted at one edge gets its response during the following cycle. Every result of that response is then visible one edge later: the next read, the test-and-set, or the grant. After a collision, `req_valid_o` stays low for exactly the current delay before the next read appears. The monitor counts the low-valid cycles since each response and compares that count with the gap stored in the queued expected item. It checks the grant level on the cycle after each test-and-set response and the grant drop one cycle after a release pulse. All outputs are sampled on the falling edge, so every check sees the value settled by the preceding rising edge.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_WR  = 2'b01,
    OP_TAS = 2'b10
  } mem_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_POLL_REQ,
    S_POLL_WAIT,
    S_TAS_REQ,
    S_TAS_WAIT,
    S_BACKOFF,
    S_HELD,
    S_REL_REQ
  } req_state_e;

  localparam logic LOCK_FREE = 1'b0;
  localparam logic LOCK_BUSY = 1'b1;
endpackage

// File: rtl/lbr_backoff.sv
module lbr_backoff #(
  parameter int DLY_MIN = 2,
  parameter int DLY_MAX = 16,
  localparam int DW = $clog2(DLY_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          collide_i,
  output logic [DW-1:0] dly_o,
  output logic          expire_o
);
  logic [DW-1:0] dly_q, cnt_q;
  logic [DW:0]   dbl;
  logic [DW-1:0] dly_nxt;

  assign dbl     = {dly_q, 1'b0};
  assign dly_nxt = (dbl > (DW+1)'(DLY_MAX)) ? DW'(DLY_MAX) : dbl[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= DW'(DLY_MIN);
      cnt_q <= '0;
    end else begin
      if (restart_i)      dly_q <= DW'(DLY_MIN);
      else if (collide_i) dly_q <= dly_nxt;

      // wait length uses the delay in force at the collision
      if (collide_i)          cnt_q <= dly_q;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign dly_o    = dly_q;
  assign expire_o = (cnt_q == DW'(1));
endmodule

// File: rtl/lbr_fsm.sv
module lbr_fsm
  import lbr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    acq_i,
  input  logic    rel_i,
  input  logic    expire_i,
  input  logic    req_ready_i,
  input  logic    rsp_valid_i,
  input  logic    rsp_old_i,
  output logic    req_valid_o,
  output mem_op_e req_op_o,
  output logic    grant_o,
  output logic    restart_o,
  output logic    collide_o
);
  req_state_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d        = st_q;
    req_valid_o = 1'b0;
    req_op_o    = OP_RD;
    grant_o     = 1'b0;
    restart_o   = 1'b0;
    collide_o   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (acq_i) begin
          restart_o = 1'b1;
          st_d      = S_POLL_REQ;
        end
      end
      S_POLL_REQ: begin
        req_valid_o = 1'b1;
        req_op_o    = OP_RD;
        if (req_ready_i) st_d = S_POLL_WAIT;
      end
      S_POLL_WAIT: begin
        if (rsp_valid_i)
          st_d = (rsp_old_i == LOCK_FREE) ? S_TAS_REQ : S_POLL_REQ;
      end
      S_TAS_REQ: begin
        req_valid_o = 1'b1;
        req_op_o    = OP_TAS;
        if (req_ready_i) st_d = S_TAS_WAIT;
      end
      S_TAS_WAIT: begin
        if (rsp_valid_i) begin
          if (rsp_old_i == LOCK_FREE) begin
            restart_o = 1'b1;
            st_d      = S_HELD;
          end else begin
            collide_o = 1'b1;
            st_d      = S_BACKOFF;
          end
        end
      end
      S_BACKOFF: begin
        if (expire_i) st_d = S_POLL_REQ;
      end
      S_HELD: begin
        grant_o = 1'b1;
        if (rel_i) st_d = S_REL_REQ;
      end
      S_REL_REQ: begin
        req_valid_o = 1'b1;
        req_op_o    = OP_WR;
        if (req_ready_i) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end
endmodule

// File: rtl/lock_backoff_req.sv
module lock_backoff_req
  import lbr_pkg::*;
#(
  parameter int DLY_MIN = 2,
  parameter int DLY_MAX = 16,
  localparam int DW = $clog2(DLY_MAX + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acq_i,
  input  logic       rel_i,
  output logic       grant_o,
  output logic       req_valid_o,
  input  logic       req_ready_i,
  output logic [1:0] req_op_o,
  output logic       req_wdata_o,
  input  logic       rsp_valid_i,
  input  logic       rsp_old_i
);
  logic          restart_w, collide_w, expire_w;
  logic [DW-1:0] dly_w;
  mem_op_e       op_w;

  lbr_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acq_i       (acq_i),
    .rel_i       (rel_i),
    .expire_i    (expire_w),
    .req_ready_i (req_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_old_i   (rsp_old_i),
    .req_valid_o (req_valid_o),
    .req_op_o    (op_w),
    .grant_o     (grant_o),
    .restart_o   (restart_w),
    .collide_o   (collide_w)
  );

  lbr_backoff #(
    .DLY_MIN (DLY_MIN),
    .DLY_MAX (DLY_MAX)
  ) u_backoff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart_w),
    .collide_i (collide_w),
    .dly_o     (dly_w),
    .expire_o  (expire_w)
  );

  assign req_op_o    = op_w;
  assign req_wdata_o = LOCK_FREE;
endmodule

// File: rtl/lbr_checker.sv
module lbr_checker #(
  parameter int DLY_MIN = 2,
  parameter int DLY_MAX = 16,
  parameter int DW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rel_i,
  input logic          grant_o,
  input logic          req_valid_o,
  input logic          req_ready_i,
  input logic [1:0]    req_op_o,
  input logic          req_wdata_o,
  input logic          rsp_valid_i,
  input logic          rsp_old_i,
  input logic          collide_i,
  input logic [DW-1:0] dly_i
);
  logic [1:0] last_op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         last_op_q <= 2'b11;
    else if (req_valid_o && req_ready_i) last_op_q <= req_op_o;
  end

  assert_busy_no_tas_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && rsp_old_i && last_op_q == 2'b00) |=> !(req_valid_o && req_op_o == 2'b10));

  assert_tas_after_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o && req_op_o == 2'b10) |-> $past(rsp_valid_i && !rsp_old_i));

  assert_grant_on_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && !rsp_old_i && last_op_q == 2'b10) |=> grant_o);

  assert_dly_double_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide_i |=> (int'(dly_i) == ((2 * int'($past(dly_i)) > DLY_MAX) ? DLY_MAX : 2 * int'($past(dly_i)))));

  assert_dly_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(dly_i) <= DLY_MAX) && (int'(dly_i) >= DLY_MIN));

  assert_release_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && rel_i) |=> (!grant_o && req_valid_o && req_op_o == 2'b01 && req_wdata_o == 1'b0));

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_op_o)));
endmodule

bind lock_backoff_req lbr_checker #(
  .DLY_MIN (DLY_MIN),
  .DLY_MAX (DLY_MAX),
  .DW      (DW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rel_i       (rel_i),
  .grant_o     (grant_o),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_op_o    (req_op_o),
  .req_wdata_o (req_wdata_o),
  .rsp_valid_i (rsp_valid_i),
  .rsp_old_i   (rsp_old_i),
  .collide_i   (collide_w),
  .dly_i       (dly_w)
);

// File: tb/tb_lock_backoff_req.sv
`timescale 1ns/1ps
module tb_lock_backoff_req;
  localparam int DMIN = 2;
  localparam int DMAX = 16;
  localparam int RD = 0, WR = 1, TAS = 2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       acq = 1'b0, rel = 1'b0;
  logic       grant, req_valid, req_wdata;
  logic       req_ready = 1'b1;
  logic [1:0] req_op;
  logic       rsp_valid = 1'b0, rsp_old = 1'b0;

  always #4 clk = ~clk;

  lock_backoff_req #(.DLY_MIN(DMIN), .DLY_MAX(DMAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .acq_i(acq), .rel_i(rel), .grant_o(grant),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_op_o(req_op),
    .req_wdata_o(req_wdata), .rsp_valid_i(rsp_valid), .rsp_old_i(rsp_old)
  );

  typedef struct { int op; bit rsp; int gap; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(int op, bit rsp, int gap);
    exp_t e;
    e.op = op; e.rsp = rsp; e.gap = gap;
    exp_q.push_back(e);
  endtask

  // monitor / memory model
  bit rsp_due = 0, rsp_val = 0, post_tas = 0, hold_pend = 0, stall_mode = 0;
  int gap = 0, hold_op = 0, stall_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      stall_cnt++;
      req_ready = !stall_mode || (stall_cnt % 3 == 0);
      if (rsp_valid) begin
        rsp_valid = 1'b0;
        gap = 0;
        if (post_tas)
          check(grant == !rsp_val, rsp_val ? "R5" : "R4", "grant after test-and-set",
                int'(grant), int'(!rsp_val));
        post_tas = 0;
      end else if (rsp_due) begin
        rsp_valid = 1'b1;
        rsp_old   = rsp_val;
        rsp_due   = 0;
      end
      if (hold_pend) begin
        check(req_valid && int'(req_op) == hold_op, "R10", "held request op",
              req_valid ? int'(req_op) : -1, hold_op);
        hold_pend = 0;
      end
      if (req_valid && req_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected request op", int'(req_op), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(req_op) == e.op, (e.op == TAS) ? "R3" : "R2", "request op", int'(req_op), e.op);
          if (e.gap >= 0)
            check(gap == e.gap, "R5", "idle cycles before request", gap, e.gap);
          if (int'(req_op) == WR) begin
            check(req_wdata == 1'b0, "R9", "release data", int'(req_wdata), 0);
          end else begin
            rsp_due  = 1;
            rsp_val  = e.rsp;
            post_tas = (int'(req_op) == TAS);
          end
        end
      end else if (req_valid) begin
        hold_pend = 1;
        hold_op   = int'(req_op);
      end else begin
        gap++;
      end
    end
  end

  task automatic do_acquire(string req);
    @(negedge clk); acq = 1'b1;
    @(negedge clk); acq = 1'b0;
    for (int i = 0; i < 2000 && !grant; i++) @(negedge clk);
    check(grant == 1'b1, req, "grant after acquire", int'(grant), 1);
    check(exp_q.size() == 0, req, "expected items left", exp_q.size(), 0);
  endtask

  task automatic do_release();
    push(WR, 1'b0, -1);
    repeat (3) @(negedge clk);
    rel = 1'b1;
    @(negedge clk); rel = 1'b0;
    check(grant == 1'b0, "R9", "grant after release", int'(grant), 0);
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, "R9", "release write missing", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(grant == 1'b0, "R1", "grant in reset", int'(grant), 0);
    check(req_valid == 1'b0, "R1", "valid in reset", int'(req_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(req_valid == 1'b0 && grant == 1'b0, "R1", "idle outputs", int'(req_valid), 0);

    // free at once
    push(RD, 0, -1); push(TAS, 0, 0);
    do_acquire("R4");
    do_release();

    // busy polls then free (R2, R3)
    push(RD, 1, -1); push(RD, 1, 0); push(RD, 1, 0); push(RD, 0, 0); push(TAS, 0, 0);
    do_acquire("R2");
    do_release();

    // repeated collisions: doubling (R6) and cap (R7)
    push(RD, 0, -1); push(TAS, 1, 0);
    push(RD, 0, 2);  push(TAS, 1, 0);
    push(RD, 0, 4);  push(TAS, 1, 0);
    push(RD, 0, 8);  push(TAS, 1, 0);
    push(RD, 0, 16); push(TAS, 1, 0);
    push(RD, 0, 16); push(TAS, 0, 0);
    do_acquire("R7");
    do_release();

    // delay back at minimum (R8), busy polls after backoff, with stalls (R10)
    stall_mode = 1;
    push(RD, 0, -1); push(TAS, 1, 0);
    push(RD, 1, DMIN); push(RD, 0, 0); push(TAS, 1, 0);
    push(RD, 0, 4); push(TAS, 0, 0);
    do_acquire("R8");
    do_release();
    stall_mode = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule